// File: doc/BRIEF.md
# Calendar Real-Time Clock with BCD Year

This block keeps wall-clock time as a calendar rather than a running seconds count. Seconds, minutes, hours, day of week, day of month and month share a single packed 32-bit time word. The four-digit year is held separately as a 16-bit BCD value. A one-cycle pulse on `sec_tick` advances the clock by one second. All carries are handled in that one step: seconds into minutes, minutes into hours, hours into days, days into months and months into years. The step accounts for month lengths, leap years, weekday rotation and a decimal year carry.

Software talks to the block through simple write and read strobes at fixed byte offsets. A new date is set in two writes: the year goes to a staging register first, then the time word. The time write commits both values in the same cycle, so the clock never shows a new year with an old time.

An alarm compares the whole calendar (time word and year) against two match registers on every tick. On a match it sets a raw flag. That flag is gated by a mask bit to drive `irq` and is cleared by a write-one-to-clear strobe.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time word reads 0x021E0000 (month 1, day 1, weekday 7 meaning Saturday, 00:00:00), the year reads 0x2000, the match registers read 0, and the mask, raw status and `irq` are 0.
- R2: Each `sec_tick` adds one second. Seconds and minutes roll from 59 to 0 and carry; hours roll from 23 to 0 and carry. With no tick and no time load the time word holds.
- R3: Time word fields are: seconds [5:0], minutes [11:6], hours [16:12], weekday [19:17] (1 = Sunday … 7 = Saturday), day of month [24:20], month [28:25] (1 = January). The time reads at offset 0x00 and the year at 0x30, with the year in bits [15:0] as BCD, century in [15:8].
- R4: At the last day of a month (30 for April, June, September and November; 31 for the other months except February), the midnight tick sets the day to 1 and advances the month.
- R5: February has 29 days when the year is divisible by 4 and not by 100, or divisible by 400; otherwise it has 28.
- R6: The weekday advances once at each midnight and wraps from 7 to 1.
- R7: The midnight tick at the end of December 31 sets the month and day to 1 and increments the BCD year with decimal carries; 9999 wraps to 0000.
- R8: A write to the year load offset 0x38 does not change the year read at 0x30. The next write to the time load offset 0x08 loads the time and commits the staged year. A time load with no year load since the previous time load leaves the year unchanged.
- R9: A time load in the same cycle as a tick wins: the loaded word appears unadvanced.
- R10: The raw alarm flag (bit 0 at 0x14) sets on a tick whose advanced time word equals the time match register (0x04) and whose advanced year equals the year match register (0x34). A match on only one of the two does not set it.
- R11: Mask bit 0 at 0x10 gates the flag: `irq` and the masked status (bit 0 at 0x18) are 1 exactly when raw and mask are both 1.
- R12: Writing 0x1C with bit 0 set clears the raw flag; with bit 0 clear it has no effect. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Alarm interrupt, raw flag gated by mask |

## Verification
The range and BCD-digit assertions assume that every loaded time word carries in-range field values and that every loaded year holds decimal digits only. The block itself does not police loads, and an illegal load would break those properties. The bench builds every load from a date chosen through its own month-length and leap-year functions, and it encodes every year through its own BCD conversion. Random dates are biased toward last-second, last-hour and last-day values, so that the carry paths are exercised while the fields stay legal.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int YEAR_DIGITS = 4;
    localparam int YEAR_W      = 4 * YEAR_DIGITS;

    // Byte offsets decoded by the register front end
    localparam int OFS_TIME_RD = 'h00;
    localparam int OFS_TIME_MT = 'h04;
    localparam int OFS_TIME_LD = 'h08;
    localparam int OFS_MASK    = 'h10;
    localparam int OFS_RAW     = 'h14;
    localparam int OFS_MSTAT   = 'h18;
    localparam int OFS_CLEAR   = 'h1C;
    localparam int OFS_YEAR_RD = 'h30;
    localparam int OFS_YEAR_MT = 'h34;
    localparam int OFS_YEAR_LD = 'h38;

    typedef struct packed {
        logic [2:0] rsvd;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    localparam cal_time_t RESET_TIME = '{rsvd: 3'd0, mon: 4'd1, mday: 5'd1,
                                         wday: 3'd7, hour: 5'd0, min: 6'd0,
                                         sec: 6'd0};
    localparam logic [YEAR_W-1:0] RESET_YEAR = 16'h2000;

    // Divisible by 4 for a two-digit BCD value: 10*t+o = 2*t+o (mod 4)
    function automatic logic bcd2_div4(input logic [7:0] v);
        logic [4:0] s;
        s = {3'b000, v[4], 1'b0} + {1'b0, v[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic leap_year(input logic [YEAR_W-1:0] y);
        if (y[7:0] == 8'h00)
            return bcd2_div4(y[15:8]);
        return bcd2_div4(y[7:0]);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon,
                                             input logic [YEAR_W-1:0] y);
        case (mon)
            4'd2:                     return leap_year(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
            default:                  return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_time_t          cur,
    input  logic [YEAR_W-1:0]  year,
    output cal_time_t          nxt,
    output logic               year_roll
);
    logic       sec_w, min_w, hr_w, day_w, mon_w;
    logic [4:0] mlen;

    always_comb begin
        mlen  = month_len(cur.mon, year);
        sec_w = cur.sec >= 6'd59;
        min_w = sec_w && (cur.min >= 6'd59);
        hr_w  = min_w && (cur.hour >= 5'd23);
        day_w = hr_w && (cur.mday >= mlen);
        mon_w = day_w && (cur.mon >= 4'd12);

        nxt     = cur;
        nxt.sec = sec_w ? 6'd0 : cur.sec + 6'd1;
        if (sec_w)
            nxt.min = min_w ? 6'd0 : cur.min + 6'd1;
        if (min_w)
            nxt.hour = hr_w ? 5'd0 : cur.hour + 5'd1;
        if (hr_w) begin
            nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
            nxt.mday = day_w ? 5'd1 : cur.mday + 5'd1;
        end
        if (day_w)
            nxt.mon = mon_w ? 4'd1 : cur.mon + 4'd1;
        year_roll = mon_w;
    end
endmodule

// File: rtl/rtc_bcd_inc.sv
module rtc_bcd_inc #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] din,
    output logic [4*DIGITS-1:0] dout
);
    logic [DIGITS-1:0] cy;
    assign cy[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] d;
        assign d = din[4*g +: 4];
        assign dout[4*g +: 4] = !cy[g] ? d : ((d >= 4'd9) ? 4'd0 : d + 4'd1);
        if (g < DIGITS - 1) begin : g_cy
            assign cy[g+1] = cy[g] && (d >= 4'd9);
        end
    end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic mask_we,
    input  logic mask_d,
    input  logic clr_we,
    input  logic clr_d,
    output logic raw,
    output logic mask,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= 1'b0;
            mask <= 1'b0;
        end else begin
            if (mask_we)
                mask <= mask_d;
            if (hit)
                raw <= 1'b1;
            else if (clr_we && clr_d)
                raw <= 1'b0;
        end
    end

    assign irq = raw & mask;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq
);
    cal_time_t          time_q, tmatch_q, time_nxt;
    logic [YEAR_W-1:0]  year_q, ymatch_q, ystage_q, year_inc, year_adv;
    logic               ypend_q, year_roll;
    logic               ld_time, ld_year, wr_tmt, wr_ymt, wr_mask, wr_clr;
    logic               alarm_hit, alarm_raw, alarm_mask;

    assign ld_time = wr_en && (wr_addr == ADDR_W'(OFS_TIME_LD));
    assign ld_year = wr_en && (wr_addr == ADDR_W'(OFS_YEAR_LD));
    assign wr_tmt  = wr_en && (wr_addr == ADDR_W'(OFS_TIME_MT));
    assign wr_ymt  = wr_en && (wr_addr == ADDR_W'(OFS_YEAR_MT));
    assign wr_mask = wr_en && (wr_addr == ADDR_W'(OFS_MASK));
    assign wr_clr  = wr_en && (wr_addr == ADDR_W'(OFS_CLEAR));

    rtc_cal_step step_i (
        .cur       (time_q),
        .year      (year_q),
        .nxt       (time_nxt),
        .year_roll (year_roll)
    );

    rtc_bcd_inc #(.DIGITS(YEAR_DIGITS)) yinc_i (
        .din  (year_q),
        .dout (year_inc)
    );

    assign year_adv  = year_roll ? year_inc : year_q;
    assign alarm_hit = sec_tick && !ld_time &&
                       (time_nxt == tmatch_q) && (year_adv == ymatch_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q   <= RESET_TIME;
            year_q   <= RESET_YEAR;
            tmatch_q <= '0;
            ymatch_q <= '0;
            ystage_q <= RESET_YEAR;
            ypend_q  <= 1'b0;
        end else begin
            if (ld_time) begin
                time_q  <= cal_time_t'(wr_data);
                ypend_q <= 1'b0;
                if (ypend_q)
                    year_q <= ystage_q;
            end else if (sec_tick) begin
                time_q <= time_nxt;
                year_q <= year_adv;
            end
            if (ld_year) begin
                ystage_q <= wr_data[YEAR_W-1:0];
                ypend_q  <= 1'b1;
            end
            if (wr_tmt)
                tmatch_q <= cal_time_t'(wr_data);
            if (wr_ymt)
                ymatch_q <= wr_data[YEAR_W-1:0];
        end
    end

    rtc_alarm alarm_i (
        .clk     (clk),
        .rst     (rst),
        .hit     (alarm_hit),
        .mask_we (wr_mask),
        .mask_d  (wr_data[0]),
        .clr_we  (wr_clr),
        .clr_d   (wr_data[0]),
        .raw     (alarm_raw),
        .mask    (alarm_mask),
        .irq     (irq)
    );

    always_comb begin
        case (rd_addr)
            ADDR_W'(OFS_TIME_RD): rd_data = time_q;
            ADDR_W'(OFS_TIME_MT): rd_data = tmatch_q;
            ADDR_W'(OFS_MASK):    rd_data = {31'd0, alarm_mask};
            ADDR_W'(OFS_RAW):     rd_data = {31'd0, alarm_raw};
            ADDR_W'(OFS_MSTAT):   rd_data = {31'd0, irq};
            ADDR_W'(OFS_YEAR_RD): rd_data = 32'(year_q);
            ADDR_W'(OFS_YEAR_MT): rd_data = 32'(ymatch_q);
            default:              rd_data = 32'd0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_bit0,
    input cal_time_t         time_q,
    input logic [YEAR_W-1:0] year_q,
    input logic              alarm_raw,
    input logic              irq
);
    logic ld_t, ld_y, clr;
    assign ld_t = wr_en && (wr_addr == ADDR_W'(OFS_TIME_LD));
    assign ld_y = wr_en && (wr_addr == ADDR_W'(OFS_YEAR_LD));
    assign clr  = wr_en && (wr_addr == ADDR_W'(OFS_CLEAR)) && wr_bit0;

    assert_time_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !ld_t) |=> $stable(time_q));

    assert_sec_step_R2: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !ld_t && time_q.sec < 6'd59) |=>
        (time_q.sec == 6'($past(time_q.sec) + 6'd1)));

    assert_field_range_R3: assert property (@(posedge clk) disable iff (rst)
        (time_q.sec <= 6'd59) && (time_q.min <= 6'd59) && (time_q.hour <= 5'd23) &&
        (time_q.wday >= 3'd1) && (time_q.mday >= 5'd1) &&
        (time_q.mon >= 4'd1) && (time_q.mon <= 4'd12));

    assert_year_bcd_R7: assert property (@(posedge clk) disable iff (rst)
        (year_q[3:0] <= 4'd9) && (year_q[7:4] <= 4'd9) &&
        (year_q[11:8] <= 4'd9) && (year_q[15:12] <= 4'd9));

    assert_year_stage_R8: assert property (@(posedge clk) disable iff (rst)
        (ld_y && !sec_tick) |=> $stable(year_q));

    assert_raw_source_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_raw) |-> $past(sec_tick));

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> alarm_raw);

    assert_clear_R12: assert property (@(posedge clk) disable iff (rst)
        (clr && !sec_tick) |=> !alarm_raw);
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_bit0   (wr_data[0]),
    .time_q    (time_q),
    .year_q    (year_q),
    .alarm_raw (alarm_raw),
    .irq       (irq)
);

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic [7:0]  rd_addr = 8'h00;
    logic [31:0] rd_data;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // model state
    int ms, mm, mh, mw, md, mo, my;

    always #2.5 clk = ~clk;

    rtc_calendar #(.ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic bit is_leap(int y);
        return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    endfunction

    function automatic int days_in(int m, int y);
        if (m == 2) return is_leap(y) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] pack(int mo_, int d_, int w_, int h_, int mi_, int s_);
        return (32'(mo_) << 25) | (32'(d_) << 20) | (32'(w_) << 17) |
               (32'(h_) << 12) | (32'(mi_) << 6) | 32'(s_);
    endfunction

    function automatic logic [31:0] to_bcd(int y);
        return {16'h0, 4'(y / 1000), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
    endfunction

    task automatic m_adv();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mw = (mw == 7) ? 1 : mw + 1;
                    md++;
                    if (md > days_in(mo, my)) begin
                        md = 1; mo++;
                        if (mo == 13) begin
                            mo = 1;
                            my = (my == 9999) ? 0 : my + 1;
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick1();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic load_cal(int y, int mo_, int d_, int w_, int h_, int mi_, int s_);
        wr(8'h38, to_bcd(y));
        wr(8'h08, pack(mo_, d_, w_, h_, mi_, s_));
        my = y; mo = mo_; md = d_; mw = w_; mh = h_; mm = mi_; ms = s_;
    endtask

    task automatic step_chk(input string rq);
        logic [31:0] v;
        tick1();
        m_adv();
        rd(8'h00, v); chk(rq, v, pack(mo, md, mw, mh, mm, ms));
        rd(8'h30, v); chk(rq, v, to_bcd(my));
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240229));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1", v, 32'h021E0000);
        rd(8'h30, v); chk("R1", v, 32'h00002000);
        rd(8'h04, v); chk("R1", v, 32'h0);
        rd(8'h34, v); chk("R1", v, 32'h0);
        rd(8'h10, v); chk("R1", v, 32'h0);
        rd(8'h14, v); chk("R1", v, 32'h0);
        chk("R1", {31'd0, irq}, 32'h0);

        // R3 field positions
        load_cal(2021, 8, 17, 3, 13, 45, 30);
        rd(8'h00, v); chk("R3", v, 32'h1116DB5E);
        rd(8'h30, v); chk("R3", v, 32'h00002021);

        // R2 second/minute/hour carries and hold without tick
        load_cal(2021, 3, 10, 4, 10, 59, 59);
        step_chk("R2");
        repeat (4) @(negedge clk);
        rd(8'h00, v); chk("R2", v, pack(3, 10, 4, 11, 0, 0));

        // R4 month ends
        load_cal(2021, 4, 30, 5, 23, 59, 59); step_chk("R4");
        rd(8'h00, v); chk("R4", v, pack(5, 1, 6, 0, 0, 0));
        load_cal(2021, 1, 31, 1, 23, 59, 59); step_chk("R4");
        load_cal(2021, 7, 30, 1, 23, 59, 59); step_chk("R4");
        rd(8'h00, v); chk("R4", v, pack(7, 31, 2, 0, 0, 0));

        // R5 leap rules
        load_cal(2024, 2, 28, 4, 23, 59, 59); step_chk("R5");
        rd(8'h00, v); chk("R5", v, pack(2, 29, 5, 0, 0, 0));
        load_cal(2023, 2, 28, 3, 23, 59, 59); step_chk("R5");
        rd(8'h00, v); chk("R5", v, pack(3, 1, 4, 0, 0, 0));
        load_cal(2100, 2, 28, 1, 23, 59, 59); step_chk("R5");
        rd(8'h00, v); chk("R5", v, pack(3, 1, 2, 0, 0, 0));
        load_cal(2000, 2, 28, 2, 23, 59, 59); step_chk("R5");
        load_cal(2024, 2, 29, 5, 23, 59, 59); step_chk("R5");

        // R6 weekday wrap
        load_cal(2022, 6, 11, 7, 23, 59, 59); step_chk("R6");
        rd(8'h00, v); chk("R6", (v >> 17) & 32'h7, 32'd1);

        // R7 year rollover with decimal carries
        load_cal(2099, 12, 31, 5, 23, 59, 59); step_chk("R7");
        rd(8'h30, v); chk("R7", v, 32'h00002100);
        load_cal(1999, 12, 31, 6, 23, 59, 59); step_chk("R7");
        load_cal(9999, 12, 31, 6, 23, 59, 59); step_chk("R7");
        rd(8'h30, v); chk("R7", v, 32'h00000000);

        // R8 staged year
        load_cal(2050, 5, 5, 1, 1, 1, 1);
        wr(8'h38, to_bcd(1999));
        rd(8'h30, v); chk("R8", v, 32'h00002050);
        wr(8'h08, pack(5, 5, 1, 1, 1, 1));
        rd(8'h30, v); chk("R8", v, 32'h00001999);
        load_cal(1999, 12, 31, 6, 23, 59, 59); step_chk("R8");
        wr(8'h08, pack(3, 3, 3, 3, 3, 3));
        rd(8'h30, v); chk("R8", v, 32'h00002000);

        // R9 load beats tick
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h08; wr_data = pack(9, 9, 2, 9, 9, 9); sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        rd(8'h00, v); chk("R9", v, pack(9, 9, 2, 9, 9, 9));

        // R10..R12 alarm
        load_cal(2030, 6, 15, 7, 12, 0, 0);
        wr(8'h04, pack(6, 15, 7, 12, 0, 1));
        wr(8'h34, 32'h2030);
        tick1();
        rd(8'h14, v); chk("R10", v, 32'h1);
        chk("R11", {31'd0, irq}, 32'h0);
        rd(8'h18, v); chk("R11", v, 32'h0);
        wr(8'h10, 32'h1);
        chk("R11", {31'd0, irq}, 32'h1);
        rd(8'h18, v); chk("R11", v, 32'h1);
        wr(8'h1C, 32'h0);
        rd(8'h14, v); chk("R12", v, 32'h1);
        wr(8'h1C, 32'h1);
        rd(8'h14, v); chk("R12", v, 32'h0);
        chk("R11", {31'd0, irq}, 32'h0);
        wr(8'h34, 32'h2031);
        wr(8'h08, pack(6, 15, 7, 12, 0, 0));
        tick1();
        rd(8'h14, v); chk("R10", v, 32'h0);
        wr(8'h34, 32'h2030);
        wr(8'h08, pack(6, 15, 7, 12, 0, 0));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h1C; wr_data = 32'h1; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        rd(8'h14, v); chk("R12", v, 32'h1);
        wr(8'h1C, 32'h1);
        wr(8'h10, 32'h0);

        // R2 random calendars biased to carry points
        for (int i = 0; i < 150; i++) begin
            int y, mo_, d_, w_, h_, mi_, s_;
            y   = $urandom_range(9999, 0);
            mo_ = $urandom_range(12, 1);
            d_  = ($urandom_range(1, 0) == 1) ? days_in(mo_, y) : $urandom_range(days_in(mo_, y), 1);
            w_  = $urandom_range(7, 1);
            h_  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
            mi_ = ($urandom_range(1, 0) == 1) ? 59 : $urandom_range(59, 0);
            s_  = ($urandom_range(2, 0) != 0) ? 59 : $urandom_range(59, 0);
            load_cal(y, mo_, d_, w_, h_, mi_, s_);
            for (int k = 0; k < 2; k++) step_chk("R2");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule